// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write single bytes in an external 64K x 8 asynchronous static RAM. The host offers a request with a 16-bit address, a direction bit and a write byte. The controller accepts the request when it shows ready. It then drives the memory's address, its two chip selects (one low-true, one high-true), its low-true output enable and low-true write enable, and its tristated data bus. When the access is complete it returns the read byte and raises done for one cycle.

The memory has no clock, so every timing limit is a span in nanoseconds. Two parameters, the clock period in nanoseconds and a speed-grade choice, fix each span. The block turns each span into a whole number of clock cycles, rounding up, with at least one cycle. All strobes come straight from flops, so none of them glitches.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held low and on the first cycle after it, mem_cs1_n=1, mem_cs2=0, mem_oe_n=1, mem_we_n=1, dq_oe=0, ready=1 and done=0.
- R2: The part is selected (mem_cs1_n=0 together with mem_cs2=1) only during an access. In the cycle where done is high, every strobe is inactive, and at least one cycle with all strobes inactive separates any two accesses.
- R3: A read holds the part selected, with mem_oe_n=0 and mem_we_n=1 and mem_addr steady, for N_RD cycles. N_RD is the largest of the cycle counts of the read cycle, the address access time and the output-enable access time. The bus value is captured on the edge that ends this window and appears on rdata with done.
- R4: A write holds the part selected, with mem_we_n=0 and mem_oe_n=1. The data bus stays released for the first N_WHZ cycles, which covers the time the memory may take to let go of the bus after write enable falls. The bus is then driven with wdata for N_WDAT cycles. N_WDAT is at least the data-setup count, and the two phases together cover the write-pulse, address-to-end-of-write and write-cycle counts. The data stays driven through the single recovery cycle that follows.
- R5: The controller never drives the data bus while mem_oe_n is low. After a read it keeps the bus released for N_OHZ recovery cycles after output enable rises.
- R6: ready is high only when the block is idle. A request is taken on an edge where req and ready are both high. ready then stays low until the edge that raises done, and done lasts exactly one cycle.
- R7: done is seen N_RD+N_OHZ edges after the accepting edge for a read, and N_WHZ+N_WDAT+1 edges after it for a write.
- R8: Each span in nanoseconds becomes ceil(ns/CLK_NS) cycles, with a minimum of 1. With FAST_GRADE=1 the spans are: read cycle 85, address access 85, output-enable access 45, output release 20, write cycle 85, write pulse 60, address-to-end-of-write 70, data setup 35, write-enable release 25. With FAST_GRADE=0 they are 100, 100, 50, 20, 100, 70, 80, 40, 30.
- R9: Measured at the pins, every write-pulse, select, address-setup, data-setup, read-cycle and bus-turnaround interval meets the configured limit.
- R10: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Host access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Host byte address |
| wdata | input | 8 | Host write byte |
| ready | output | 1 | Block idle, request will be taken |
| rdata | output | 8 | Byte returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address bus |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| dq_out | output | 8 | Value placed on the data bus |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 8 | Value sampled from the data bus |

## Verification
The bench connects a timing-aware memory model. This model returns the complement of the stored byte until the address and output-enable access times have run out, so a read window that is one cycle too short comes back with the wrong data. The model also records any write enable that rises too early, and any write data that settles too late. It flags the controller if it drives the bus while the memory is driving or in the memory's release window after either enable changes. A design that drove the bus as soon as write enable fell, or released it too soon after output enable, would trip this check. Every access is compared cycle by cycle against its expected strobe pattern and its latency. Some accesses are issued back to back, and the bench checks that these never merge without an idle gap.

// File: rtl/asram_pkg.sv
`timescale 1ns/100ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSET,
        ST_WDAT,
        ST_RECOV
    } asram_st_e;

    // Nanoseconds to whole cycles, rounded up, never below one cycle.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_window.sv
`timescale 1ns/100ps
module asram_window #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R8: once a window has run out it stays out until reloaded
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/asram_dbus.sv
`timescale 1ns/100ps
module asram_dbus #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drive_nxt,
    input  logic [DW-1:0] wdata_nxt,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic          dq_oe,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic          oe;
        logic [DW-1:0] out;
        logic [DW-1:0] rd;
    } bus_t;

    bus_t b_d, b_q;

    always_comb begin
        b_d    = b_q;
        b_d.oe = drive_nxt;
        if (drive_nxt) b_d.out = wdata_nxt;
        if (capture)   b_d.rd  = dq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign dq_oe  = b_q.oe;
    assign dq_out = b_q.out;
    assign rdata  = b_q.rd;

    // R10: captured byte holds steady unless a capture happened
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata));

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/100ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int FAST_GRADE = 1,
    parameter int AW         = 16,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs1_n,
    output logic          mem_cs2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    input  logic [DW-1:0] dq_in
);
    // Spans in nanoseconds for the chosen grade
    localparam int unsigned T_RC  = FAST_GRADE ? 85  : 100;
    localparam int unsigned T_AA  = FAST_GRADE ? 85  : 100;
    localparam int unsigned T_OE  = FAST_GRADE ? 45  : 50;
    localparam int unsigned T_OHZ = 20;
    localparam int unsigned T_WC  = FAST_GRADE ? 85  : 100;
    localparam int unsigned T_WP  = FAST_GRADE ? 60  : 70;
    localparam int unsigned T_AW  = FAST_GRADE ? 70  : 80;
    localparam int unsigned T_DW  = FAST_GRADE ? 35  : 40;
    localparam int unsigned T_WHZ = FAST_GRADE ? 25  : 30;

    // Cycle counts
    localparam int unsigned N_RD   = umax(ns_to_cyc(T_RC, CLK_NS),
                                     umax(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_OE, CLK_NS)));
    localparam int unsigned N_OHZ  = ns_to_cyc(T_OHZ, CLK_NS);
    localparam int unsigned N_WHZ  = ns_to_cyc(T_WHZ, CLK_NS);
    localparam int unsigned N_DWC  = ns_to_cyc(T_DW, CLK_NS);
    localparam int unsigned N_WLO  = umax(ns_to_cyc(T_WP, CLK_NS),
                                     umax(ns_to_cyc(T_AW, CLK_NS), ns_to_cyc(T_WC, CLK_NS)));
    localparam int unsigned N_WDAT = (N_WLO > N_WHZ) ? umax(N_DWC, N_WLO - N_WHZ) : N_DWC;
    localparam int unsigned N_WREC = 1;
    localparam int unsigned N_MAX  = umax(umax(N_RD, N_OHZ), umax(N_WHZ, N_WDAT));
    localparam int          CW     = $clog2(N_MAX + 1) + 1;

    typedef struct packed {
        asram_st_e     st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic          cs1_n;
        logic          cs2;
        logic          oe_n;
        logic          we_n;
        logic          ready;
        logic          done;
    } regs_t;

    localparam regs_t RESET_V = '{
        st: ST_IDLE, addr: '0, wd: '0, cs1_n: 1'b1, cs2: 1'b0,
        oe_n: 1'b1, we_n: 1'b1, ready: 1'b1, done: 1'b0
    };

    regs_t         s_d, s_q;
    logic          win_load;
    logic [CW-1:0] win_val;
    logic          win_expired;
    logic          drive_nxt;
    logic          capture;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        win_load  = 1'b0;
        win_val   = '0;
        drive_nxt = dq_oe;
        capture   = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    s_d.addr  = addr;
                    s_d.wd    = wdata;
                    s_d.ready = 1'b0;
                    s_d.cs1_n = 1'b0;
                    s_d.cs2   = 1'b1;
                    win_load  = 1'b1;
                    if (we) begin
                        s_d.st   = ST_WSET;
                        s_d.we_n = 1'b0;
                        win_val  = CW'(N_WHZ - 1);
                    end else begin
                        s_d.st   = ST_READ;
                        s_d.oe_n = 1'b0;
                        win_val  = CW'(N_RD - 1);
                    end
                end
            end
            ST_READ: begin
                if (win_expired) begin
                    capture   = 1'b1;
                    s_d.st    = ST_RECOV;
                    s_d.cs1_n = 1'b1;
                    s_d.cs2   = 1'b0;
                    s_d.oe_n  = 1'b1;
                    win_load  = 1'b1;
                    win_val   = CW'(N_OHZ - 1);
                end
            end
            ST_WSET: begin
                if (win_expired) begin
                    s_d.st    = ST_WDAT;
                    drive_nxt = 1'b1;
                    win_load  = 1'b1;
                    win_val   = CW'(N_WDAT - 1);
                end
            end
            ST_WDAT: begin
                if (win_expired) begin
                    s_d.st    = ST_RECOV;
                    s_d.cs1_n = 1'b1;
                    s_d.cs2   = 1'b0;
                    s_d.we_n  = 1'b1;
                    win_load  = 1'b1;
                    win_val   = CW'(N_WREC - 1);
                end
            end
            ST_RECOV: begin
                if (win_expired) begin
                    s_d.st    = ST_IDLE;
                    s_d.ready = 1'b1;
                    s_d.done  = 1'b1;
                    drive_nxt = 1'b0;
                end
            end
            default: s_d = RESET_V;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RESET_V;
        else        s_q <= s_d;
    end

    asram_window #(.CW(CW)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (win_val),
        .expired  (win_expired)
    );

    asram_dbus #(.DW(DW)) u_dbus (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_nxt (drive_nxt),
        .wdata_nxt (s_q.wd),
        .capture   (capture),
        .dq_in     (dq_in),
        .dq_oe     (dq_oe),
        .dq_out    (dq_out),
        .rdata     (rdata)
    );

    assign ready     = s_q.ready;
    assign done      = s_q.done;
    assign mem_addr  = s_q.addr;
    assign mem_cs1_n = s_q.cs1_n;
    assign mem_cs2   = s_q.cs2;
    assign mem_oe_n  = s_q.oe_n;
    assign mem_we_n  = s_q.we_n;

    // R5: no drive while the memory's outputs are enabled
    a_r5_no_drive_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !dq_oe);
    // R5: bus still released on the cycle after output enable rises
    a_r5_release_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |=> !dq_oe);
    // R4: write enable and output enable never low together
    a_r4_we_excl_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    // R4: bus released when write enable falls
    a_r4_no_drive_at_we_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !dq_oe);
    // R3: address steady while the part stays selected
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && !$past(mem_cs1_n)) |-> $stable(mem_addr));
    // R6: done is a single-cycle pulse seen together with ready
    a_r6_done_one: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);
    // R2: strobes inactive whenever the block returns to idle
    a_r2_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n));

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/100ps
module asram_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FAST       = 1;

    // Spans (ns) and derived cycle counts, from R8
    localparam int T_RC  = FAST ? 85 : 100;
    localparam int T_AA  = FAST ? 85 : 100;
    localparam int T_OE  = FAST ? 45 : 50;
    localparam int T_OHZ = 20;
    localparam int T_WC  = FAST ? 85 : 100;
    localparam int T_WP  = FAST ? 60 : 70;
    localparam int T_AW  = FAST ? 70 : 80;
    localparam int T_DW  = FAST ? 35 : 40;
    localparam int T_WHZ = FAST ? 25 : 30;

    function automatic int cyc(int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD   = mx(cyc(T_RC), mx(cyc(T_AA), cyc(T_OE)));
    localparam int E_OHZ  = cyc(T_OHZ);
    localparam int E_WHZ  = cyc(T_WHZ);
    localparam int E_WLO  = mx(cyc(T_WP), mx(cyc(T_AW), cyc(T_WC)));
    localparam int E_WDAT = mx(cyc(T_DW), E_WLO - E_WHZ);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, done, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, dq_oe;
    logic [7:0]  rdata, dq_out, dq_in;
    logic [15:0] mem_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl #(.CLK_NS(CLK_PERIOD), .FAST_GRADE(FAST)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ready(ready), .rdata(rdata), .done(done), .mem_addr(mem_addr),
        .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // ---------------- behavioural memory model ----------------
    logic [7:0] mem [int];
    logic       sel, wov, rov, mdrive;
    logic [7:0] mval = '0;
    realtime t_addr = -1000, t_sel = -1000, t_oe_fall = -1000, t_oe_rise = -1000;
    realtime t_we_fall = -1000, t_data = -1000, t_w_start = -1000, t_r_start = -1000;
    int viol_w = 0, viol_r = 0, viol_c = 0;

    assign sel    = !mem_cs1_n && mem_cs2;
    assign wov    = sel && !mem_we_n;
    assign rov    = sel && !mem_oe_n && mem_we_n;
    assign mdrive = rov;
    assign dq_in  = dq_oe ? dq_out : (mdrive ? mval : 8'h00);

    always @(mem_addr)           t_addr    = $realtime;
    always @(posedge sel)        t_sel     = $realtime;
    always @(negedge mem_oe_n)   t_oe_fall = $realtime;
    always @(posedge mem_oe_n)   t_oe_rise = $realtime;
    always @(negedge mem_we_n)   t_we_fall = $realtime;
    always @(dq_out or dq_oe)    t_data    = $realtime;
    always @(posedge wov)        t_w_start = $realtime;
    always @(posedge rov)        t_r_start = $realtime;

    always @(negedge wov) begin
        if ($realtime - t_w_start < T_WP || $realtime - t_addr < T_AW ||
            $realtime - t_sel < T_AW || !dq_oe || $realtime - t_data < T_DW) begin
            viol_w++;
            $display("model: write timing violation at %0t", $realtime);
        end
        mem[int'(mem_addr)] = dq_out;
    end

    always @(negedge rov) begin
        if ($realtime - t_r_start < T_RC) begin
            viol_r++;
            $display("model: read cycle too short at %0t", $realtime);
        end
    end

    initial begin
        logic [7:0] stored;
        #0.5;
        forever begin
            #1;
            stored = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
            if ($realtime - t_addr >= T_AA && $realtime - t_sel >= T_AA &&
                $realtime - t_oe_fall >= T_OE)
                mval = stored;
            else
                mval = ~stored;
            if (dq_oe && (mdrive || $realtime - t_oe_rise < T_OHZ ||
                          $realtime - t_we_fall < T_WHZ)) begin
                viol_c++;
                $display("model: bus contention at %0t", $realtime);
            end
        end
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0;
    logic [7:0] sb [int];
    bit finished = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // One access; compares strobes every cycle against the expected pattern.
    task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d);
        int k, lim, bad;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 1'b0;
        lim = w ? (E_WHZ + E_WDAT + 1) : (E_RD + E_OHZ);
        k = 0; bad = 0;
        while (!done && k <= lim + 2) begin
            if (ready) bad++;                                   // R6
            if (w) begin
                if (k < E_WHZ + E_WDAT) begin                   // R4
                    if (!(sel && !mem_we_n && mem_oe_n && mem_addr == a)) bad++;
                    if (k < E_WHZ && dq_oe) bad++;
                    if (k >= E_WHZ && !(dq_oe && dq_out == d)) bad++;
                end else begin
                    if (!(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && dq_oe)) bad++;
                end
            end else begin
                if (k < E_RD) begin                             // R3
                    if (!(sel && !mem_oe_n && mem_we_n && mem_addr == a)) bad++;
                    if (dq_oe) bad++;                           // R5
                end else begin
                    if (!(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !dq_oe)) bad++;
                end
            end
            @(negedge clk);
            k++;
        end
        check(bad == 0, w ? "R4 R6 write strobe pattern" : "R3 R5 R6 read strobe pattern", bad, 0);
        check(k == lim, "R7 R8 latency to done", k, lim);
        // R2: done cycle has every strobe inactive and bus released
        check(done && ready && mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !dq_oe,
              "R2 idle strobes with done",
              {done, ready, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, dq_oe}, 7'b1110110);
        if (w) sb[int'(a)] = d;
        else check(rdata == (sb.exists(int'(a)) ? sb[int'(a)] : 8'h00), "R10 read-back data",
                   rdata, sb.exists(int'(a)) ? sb[int'(a)] : 8'h00);
        @(negedge clk);
        check(!done, "R6 done single cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while held and one cycle after release
        check(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !dq_oe && ready && !done,
              "R1 reset state", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, dq_oe, ready, done},
              7'b1011010);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !dq_oe && ready && !done,
              "R1 state after release", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, dq_oe, ready, done},
              7'b1011010);

        // boundary addresses
        access(1'b1, 16'h0000, 8'hC3);
        access(1'b1, 16'hFFFF, 8'h3C);
        access(1'b0, 16'h0000, 8'h00);
        access(1'b0, 16'hFFFF, 8'h00);
        // sweep of spread addresses
        for (int i = 0; i < 200; i++) begin
            logic [15:0] a;
            a = 16'(i * 331 + 7);
            access(1'b1, a, pat(a));
        end
        for (int i = 199; i >= 0; i--) begin
            logic [15:0] a;
            a = 16'(i * 331 + 7);
            access(1'b0, a, 8'h00);
        end
        // overwrite, alternating directions back to back
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a;
            a = 16'(i * 331 + 7);
            access(1'b1, a, ~pat(a) + 8'(i));
            access(1'b0, a, 8'h00);
        end
        // all-ones / all-zeros data on the same cell
        access(1'b1, 16'h8000, 8'hFF);
        access(1'b0, 16'h8000, 8'h00);
        access(1'b1, 16'h8000, 8'h00);
        access(1'b0, 16'h8000, 8'h00);

        check(viol_w + viol_r + viol_c == 0, "R9 pin timing intervals",
              viol_w + viol_r + viol_c, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired R6 actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule